// File: doc/BRIEF.md
# Line Clamp Pulse Generator

This block produces one active-low clamp pulse per horizontal line for a video front end. It takes a polarity-normalised, active-low horizontal sync together with a flag that says whether sync is present. A signed control word decides where the pulse sits and how wide it is. A control word well below zero places the pulse on the back porch, just after sync ends. A control word well above zero places it on the sync tip, a small fraction of the line period after sync begins. The further the word is from zero, the narrower the pulse.

The line period is measured in system clocks from one sync leading edge to the next. The sync-tip delay is derived from that measurement. When sync is absent and the block is in sync-tip placement, a free-running counter set to a programmed minimum-rate period keeps the pulses coming, so an overlay or clamp circuit further down the chain never starves. A band around zero holds the current placement, so a control word that hovers near the changeover cannot make the pulse jump between positions. A pulse that has already been scheduled always completes with the width and placement it was scheduled with.

Top module: `clamp_pulse_gen`

## Requirements
- R1: After reset, clamp_n is high (inactive) and the placement is back porch (default parameters).
- R2: In back-porch placement, when a clock edge first samples sync_n high after low while sync_valid is 1, clamp_n goes low at the BP_DLY-th rising edge after that edge. A falling sync_n schedules no pulse in this placement.
- R3: The pulse stays low for W clocks, with W = MAX_W - (|clamp_ctrl| >> SCALE_SH). W is forced to 1 when that shifted magnitude is MAX_W or more. So, for example, -40 gives 14, -60 gives 9 and -100 gives 1 with the defaults (MAX_W 24, SCALE_SH 2).
- R4: In sync-tip placement with sync_valid 1, when a clock edge first samples sync_n low after high, clamp_n goes low D edges later. D = (P >> 6) + (P >> 7), with a floor of 1. P is the line period in clocks measured between the two previous valid leading edges. A rising sync_n schedules no pulse in this placement.
- R5: A signed clamp_ctrl above +HYST selects sync-tip placement, one below -HYST selects back-porch placement, and any value from -HYST to +HYST keeps the current placement (HYST 16 by default).
- R6: In sync-tip placement with sync_valid 0, pulses of width W repeat every min_period clocks. Their delay is computed as in R4, with min_period in place of P.
- R7: In back-porch placement with sync_valid 0, no pulse is produced, whatever sync_n does.
- R8: A pulse already scheduled or in progress completes with the width it was scheduled with, even if clamp_ctrl changes meanwhile. Triggers that arrive while a pulse is pending are ignored. The new control setting applies from the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Normalised active-low horizontal sync |
| sync_valid | input | 1 | High while a horizontal sync source is present |
| clamp_ctrl | input | CTRL_W | Signed placement and width control |
| min_period | input | PER_W | Free-run line period in clocks at the minimum rate |
| clamp_n | output | 1 | Active-low clamp pulse |

## Verification
The assertions take for granted that every line is longer than the pulse delay plus its width. They also assume that min_period is at least 2 and exceeds the free-run delay plus width, and that sync_valid changes only between lines. The stimulus keeps within these limits: back-porch lines are 100 clocks long with 20 low, sync-tip lines are 640 clocks long with 40 low, and min_period is 300 against a delay of 6 and a width of 14. Control changes are made between lines, except in the one scenario that changes the control in the middle of a pulse on purpose.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
    typedef enum logic {
        MODE_PORCH = 1'b0,
        MODE_TIP   = 1'b1
    } clamp_mode_e;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_WAIT = 2'd1,
        SH_LOW  = 2'd2
    } shaper_st_e;
endpackage

// File: rtl/clamp_ctrl_decode.sv
module clamp_ctrl_decode
    import clamp_pkg::*;
#(
    parameter int CTRL_W   = 8,
    parameter int HYST     = 16,
    parameter int MAX_W    = 24,
    parameter int SCALE_SH = 2,
    parameter int WID_W    = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic signed [CTRL_W-1:0] ctrl,
    output clamp_mode_e              mode,
    output logic [WID_W-1:0]         width
);
    localparam logic signed [CTRL_W-1:0] HI_LIM = CTRL_W'(HYST);
    localparam logic signed [CTRL_W-1:0] LO_LIM = -HI_LIM;

    typedef struct packed {
        clamp_mode_e mode;
    } dec_t;

    dec_t d, q;
    logic [CTRL_W-1:0] mag;
    logic [31:0]       sh32;

    always_comb begin
        d = q;
        if (ctrl > HI_LIM)      d.mode = MODE_TIP;
        else if (ctrl < LO_LIM) d.mode = MODE_PORCH;

        mag  = ctrl[CTRL_W-1] ? (~$unsigned(ctrl) + 1'b1) : $unsigned(ctrl);
        sh32 = 32'(mag >> SCALE_SH);
        if (sh32 >= 32'(MAX_W)) width = WID_W'(1);
        else                    width = WID_W'(32'(MAX_W) - sh32);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{mode: MODE_PORCH};
        else        q <= d;
    end

    assign mode = q.mode;
endmodule

// File: rtl/clamp_line_timer.sv
module clamp_line_timer
    import clamp_pkg::*;
#(
    parameter int PER_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_n,
    input  logic             sync_valid,
    input  clamp_mode_e      mode,
    input  logic [PER_W-1:0] min_period,
    output logic             lead,
    output logic             trail,
    output logic             tick,
    output logic [PER_W-1:0] tip_dly
);
    localparam logic [PER_W-1:0] SAT = '1;

    typedef struct packed {
        logic             s;
        logic [PER_W-1:0] per_cnt;
        logic [PER_W-1:0] per;
        logic [PER_W-1:0] fr;
    } lt_t;

    lt_t d, q;
    logic             run;
    logic [PER_W-1:0] cnt_inc;
    logic [PER_W-1:0] src;
    logic [PER_W-1:0] dsum;

    always_comb begin
        d       = q;
        lead    = sync_valid && q.s && !sync_n;
        trail   = sync_valid && !q.s && sync_n;
        run     = (mode == MODE_TIP) && !sync_valid;
        tick    = run && ((q.fr + 1'b1) >= min_period);
        cnt_inc = (q.per_cnt == SAT) ? SAT : q.per_cnt + 1'b1;

        d.s       = sync_n;
        d.per_cnt = cnt_inc;
        if (lead) begin
            d.per_cnt = '0;
            d.per     = cnt_inc;
        end
        d.fr = (run && !tick) ? q.fr + 1'b1 : '0;

        src     = sync_valid ? q.per : min_period;
        dsum    = (src >> 6) + (src >> 7);
        tip_dly = (dsum == '0) ? PER_W'(1) : dsum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s: 1'b1, per_cnt: '0, per: '0, fr: '0};
        else        q <= d;
    end
endmodule

// File: rtl/clamp_shaper.sv
module clamp_shaper
    import clamp_pkg::*;
#(
    parameter int PER_W = 12,
    parameter int WID_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [PER_W-1:0] dly,
    input  logic [WID_W-1:0] wid,
    output logic             clamp_n,
    output logic [WID_W-1:0] wid_lat
);
    typedef struct packed {
        shaper_st_e       st;
        logic [PER_W-1:0] cnt;
        logic [WID_W-1:0] wl;
        logic             out;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d = q;
        unique case (q.st)
            SH_IDLE: if (trig) begin
                d.st  = SH_WAIT;
                d.cnt = dly;
                d.wl  = wid;
            end
            SH_WAIT: if (q.cnt <= PER_W'(1)) begin
                d.st  = SH_LOW;
                d.cnt = PER_W'(q.wl);
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
            SH_LOW: if (q.cnt <= PER_W'(1)) begin
                d.st  = SH_IDLE;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt - 1'b1;
            end
            default: d.st = SH_IDLE;
        endcase
        d.out = (d.st != SH_LOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: SH_IDLE, cnt: '0, wl: '0, out: 1'b1};
        else        q <= d;
    end

    assign clamp_n = q.out;
    assign wid_lat = q.wl;
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
    import clamp_pkg::*;
#(
    parameter int CTRL_W   = 8,
    parameter int PER_W    = 12,
    parameter int HYST     = 16,
    parameter int MAX_W    = 24,
    parameter int SCALE_SH = 2,
    parameter int BP_DLY   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sync_n,
    input  logic                     sync_valid,
    input  logic signed [CTRL_W-1:0] clamp_ctrl,
    input  logic [PER_W-1:0]         min_period,
    output logic                     clamp_n
);
    localparam int WID_W = $clog2(MAX_W + 1);

    clamp_mode_e      mode_w;
    logic [WID_W-1:0] width_w;
    logic [WID_W-1:0] sh_wid;
    logic             lead_w, trail_w, tick_w, trig_w;
    logic [PER_W-1:0] tip_dly_w, dly_w;

    clamp_ctrl_decode #(
        .CTRL_W(CTRL_W), .HYST(HYST), .MAX_W(MAX_W),
        .SCALE_SH(SCALE_SH), .WID_W(WID_W)
    ) dec_i (
        .clk(clk), .rst_n(rst_n), .ctrl(clamp_ctrl),
        .mode(mode_w), .width(width_w)
    );

    clamp_line_timer #(.PER_W(PER_W)) lt_i (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sync_valid(sync_valid),
        .mode(mode_w), .min_period(min_period),
        .lead(lead_w), .trail(trail_w), .tick(tick_w), .tip_dly(tip_dly_w)
    );

    always_comb begin
        if (mode_w == MODE_TIP) begin
            trig_w = sync_valid ? lead_w : tick_w;
            dly_w  = tip_dly_w;
        end else begin
            trig_w = trail_w;
            dly_w  = PER_W'(BP_DLY);
        end
    end

    clamp_shaper #(.PER_W(PER_W), .WID_W(WID_W)) sh_i (
        .clk(clk), .rst_n(rst_n), .trig(trig_w), .dly(dly_w), .wid(width_w),
        .clamp_n(clamp_n), .wid_lat(sh_wid)
    );
endmodule

// File: rtl/clamp_pulse_chk.sv
module clamp_pulse_chk #(
    parameter int CTRL_W = 8,
    parameter int HYST   = 16,
    parameter int MAX_W  = 24,
    parameter int WID_W  = 5
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     clamp_n,
    input logic signed [CTRL_W-1:0] ctrl,
    input logic                     mode,
    input logic [WID_W-1:0]         wid_lat
);
    localparam logic signed [CTRL_W-1:0] HI_LIM = CTRL_W'(HYST);
    localparam logic signed [CTRL_W-1:0] LO_LIM = -HI_LIM;

    logic [31:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_run <= '0;
        else if (!clamp_n) low_run <= low_run + 1;
        else               low_run <= '0;
    end

    a_r3_low_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= 32'(MAX_W));

    a_r5_tip_select: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl > HI_LIM) |=> mode);

    a_r5_porch_select: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl < LO_LIM) |=> !mode);

    a_r5_band_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl >= LO_LIM && ctrl <= HI_LIM) |=> $stable(mode));

    a_r8_width_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!clamp_n && $past(!clamp_n)) |-> $stable(wid_lat));
endmodule

bind clamp_pulse_gen clamp_pulse_chk #(
    .CTRL_W(CTRL_W), .HYST(HYST), .MAX_W(MAX_W), .WID_W(WID_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .clamp_n(clamp_n), .ctrl(clamp_ctrl),
    .mode(mode_w), .wid_lat(sh_wid)
);

// File: tb/clamp_pulse_gen_tb_top.sv
`timescale 1ns/1ps
module clamp_pulse_gen_tb_top;
    localparam int BP_DLY = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sync_n = 1'b1;
    logic              sync_valid = 1'b0;
    logic signed [7:0] clamp_ctrl = 8'sd0;
    logic [11:0]       min_period = 12'd300;
    logic              clamp_n;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int cyc = 0, fall_cyc = 0, prev_fall = 0, rise_cyc = 0, nfalls = 0;
    int lead_cyc = 0, trail_cyc = 0;
    logic prev_c = 1'b1;

    always #5 clk = ~clk;

    clamp_pulse_gen dut_i (
        .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sync_valid(sync_valid),
        .clamp_ctrl(clamp_ctrl), .min_period(min_period), .clamp_n(clamp_n)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!clamp_n && prev_c) begin
            prev_fall = fall_cyc;
            fall_cyc  = cyc;
            nfalls    = nfalls + 1;
        end
        if (clamp_n && !prev_c) rise_cyc = cyc;
        prev_c = clamp_n;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic line(input int len, input int lo);
        sync_n = 1'b0; lead_cyc = cyc;
        step(lo);
        sync_n = 1'b1; trail_cyc = cyc;
        step(len - lo);
    endtask

    task automatic t_reset;
        step(1);
        check(clamp_n === 1'b1, "R1 reset clamp_n", int'(clamp_n), 1);
        rst_n = 1'b1;
        step(20);
        check(nfalls == 0, "R1 idle after reset", nfalls, 0);
        // porch default: sync edges with valid schedule from trailing edge
        sync_valid = 1'b1;
        clamp_ctrl = 8'sd0;
        line(100, 20);
        check(fall_cyc - trail_cyc == BP_DLY + 1, "R1 default porch delay",
              fall_cyc - trail_cyc, BP_DLY + 1);
    endtask

    task automatic t_porch;
        int n0;
        clamp_ctrl = -8'sd40; sync_valid = 1'b1;
        repeat (2) line(100, 20);
        n0 = nfalls;
        line(100, 20);
        check(nfalls - n0 == 1, "R2 one pulse per line", nfalls - n0, 1);
        check(fall_cyc - trail_cyc == BP_DLY + 1, "R2 porch delay",
              fall_cyc - trail_cyc, BP_DLY + 1);
        check(rise_cyc - fall_cyc == 14, "R3 width ctrl -40", rise_cyc - fall_cyc, 14);
        clamp_ctrl = -8'sd60;
        line(100, 20);
        check(rise_cyc - fall_cyc == 9, "R3 width ctrl -60", rise_cyc - fall_cyc, 9);
        clamp_ctrl = -8'sd100;
        line(100, 20);
        check(rise_cyc - fall_cyc == 1, "R3 width floor ctrl -100", rise_cyc - fall_cyc, 1);
    endtask

    task automatic t_tip;
        int n0;
        clamp_ctrl = 8'sd40;
        repeat (2) line(640, 40);
        n0 = nfalls;
        line(640, 40);
        check(nfalls - n0 == 1, "R4 trailing edge ignored", nfalls - n0, 1);
        check(fall_cyc - lead_cyc == 16, "R4 tip delay P=640", fall_cyc - lead_cyc, 16);
        check(rise_cyc - fall_cyc == 14, "R4 tip width ctrl 40", rise_cyc - fall_cyc, 14);
        clamp_ctrl = 8'sd100;
        line(640, 40);
        check(rise_cyc - fall_cyc == 1, "R3 tip width floor ctrl 100", rise_cyc - fall_cyc, 1);
    endtask

    task automatic t_hyst;
        clamp_ctrl = -8'sd10;
        line(640, 40);
        check(fall_cyc - lead_cyc == 16, "R5 band keeps tip", fall_cyc - lead_cyc, 16);
        check(rise_cyc - fall_cyc == 22, "R5 band width ctrl -10", rise_cyc - fall_cyc, 22);
        clamp_ctrl = -8'sd20;
        line(640, 40);
        check(fall_cyc - trail_cyc == BP_DLY + 1, "R5 beyond band to porch",
              fall_cyc - trail_cyc, BP_DLY + 1);
        check(rise_cyc - fall_cyc == 19, "R5 porch width ctrl -20", rise_cyc - fall_cyc, 19);
    endtask

    task automatic t_nosync_porch;
        int n0;
        clamp_ctrl = -8'sd40; sync_valid = 1'b0;
        step(2);
        n0 = nfalls;
        repeat (5) line(100, 20);
        step(1000);
        check(nfalls == n0, "R7 no pulse in porch without sync", nfalls - n0, 0);
    endtask

    task automatic t_freerun;
        clamp_ctrl = 8'sd40; sync_valid = 1'b0; min_period = 12'd300;
        step(1000);
        check(fall_cyc - prev_fall == 300, "R6 free-run period",
              fall_cyc - prev_fall, 300);
        check(rise_cyc - fall_cyc == 14, "R6 free-run width", rise_cyc - fall_cyc, 14);
    endtask

    task automatic t_inprog;
        clamp_ctrl = -8'sd40; sync_valid = 1'b1;
        step(10);
        line(100, 20);
        sync_n = 1'b0; lead_cyc = cyc;
        step(20);
        sync_n = 1'b1; trail_cyc = cyc;
        step(BP_DLY + 2);
        check(clamp_n === 1'b0, "R8 pulse under way", int'(clamp_n), 0);
        clamp_ctrl = 8'sd100;
        step(100 - 20 - (BP_DLY + 2));
        check(rise_cyc - fall_cyc == 14, "R8 width kept after ctrl change",
              rise_cyc - fall_cyc, 14);
        line(100, 20);
        check(fall_cyc - lead_cyc == 2, "R8 new setting next line delay",
              fall_cyc - lead_cyc, 2);
        check(rise_cyc - fall_cyc == 1, "R8 new setting next line width",
              rise_cyc - fall_cyc, 1);
    endtask

    initial begin
        t_reset;
        t_porch;
        t_tip;
        t_hyst;
        t_nosync_porch;
        t_freerun;
        t_inprog;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule